// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Controller

This block lets a clocked system read and write an external asynchronous static memory of 262,144 sixteen-bit words. The memory word is split into two byte lanes: bits 7:0 form the lower lane and bits 15:8 the upper lane. The host issues a single-cycle request with a write flag, an 18-bit word address, write data and one strobe per lane. It receives a one-cycle done pulse and, for reads, the captured word.

All memory timing is met by counting clock cycles. The clock period and each nanosecond limit of the memory are parameters. The cycle counts are derived from them at elaboration: the required time divided by the period, rounded up, and never less than one. Write enable and chip enable go low together. Output enable stays high for the whole write and for the recovery cycle after it. The data drivers are on only while the write pulse is active.

The bidirectional memory data bus is brought out as three ports: a drive value, a drive enable and a sampled input. The tristate pad belongs to the chip's I/O ring. Between accesses chip enable returns high, which puts the memory in standby.

Top module: `sram_byte_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is all ones, `mem_dq_oe` is 0 and `done` is 0.
- R2: The 18-bit `addr` is placed unchanged on `mem_addr` for the whole access, so every one of the 262,144 words, including address 0x3FFFF, is reached separately.
- R3: A write holds `mem_ce_n` and `mem_we_n` low together for exactly WR_LOW cycles. WR_LOW is the largest of ceil(12 ns/T), ceil(8 ns/T) and ceil(15 ns/T)-1, with a minimum of 1. During those cycles address, byte enables and the driven data stay unchanged and `mem_dq_oe` is 1.
- R4: `lane_sel` bit 0 pulls `mem_be_n[0]` low and selects data bits 7:0. Bit 1 pulls `mem_be_n[1]` low and selects bits 15:8. A write leaves the unselected lane of the stored word unchanged.
- R5: `mem_oe_n` stays 1 in every cycle in which `mem_we_n` is 0.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly RD_LOW cycles. RD_LOW is the largest of ceil(15 ns/T), ceil(7 ns/T) and ceil(7 ns/T), with a minimum of 1. The word is captured on the clock edge that ends that count.
- R7: In `rdata`, a lane whose `lane_sel` bit was 0 during the read returns 0x00.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. `mem_oe_n` never falls in the cycle right after one with `mem_dq_oe` at 1.
- R9: A request with `lane_sel` = 00 starts no memory cycle (`mem_ce_n` stays 1). `done` is asserted by the accepting clock edge itself.
- R10: `done` is high for exactly one cycle. It is set by the clock edge WR_LOW+1 edges after the accepting edge for a write, and RD_LOW edges after it for a read.
- R11: A request raised while an access is in progress is ignored and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Single-cycle access request, taken only when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| lane_sel | input | 2 | Byte lane strobes, bit 0 lower, bit 1 upper |
| rdata | output | 16 | Captured read word, unselected lanes zero |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory byte enables, active low, bit 0 lower lane |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Value driven onto the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for the memory data bus |
| mem_dq_in | input | 16 | Value sampled from the memory data bus |

## Verification
The bench builds the controller with a 5 ns period parameter, which gives WR_LOW = 3 and RD_LOW = 3. With the default 20 ns period every count collapses to one cycle. The multi-cycle counts let the bench memory model tell an exact pulse length from one that is a cycle short or long. They also let the model return wrong data until the access count has elapsed, so an early capture shows up. Walking-one addresses across all 18 bits, plus every combination of write lanes and read lanes on a few words, cover address aliasing and lane masking. Back-to-back write-then-read sequences exercise bus turnaround.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the byte-lane static
// memory controller. Assumes all durations are given in picoseconds.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RECOVER = 2'd2,
        ST_READ    = 2'd3
    } seq_state_t;

    // Round a duration up to whole clock cycles, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned dur_ps,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (dur_ps + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Down-counter that times one memory access phase.
// Assumes load_val is the phase length minus one; expired is high in the
// last cycle of the phase.
module sram_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a new access, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_datapath.sv
// Holds the address, write word and lane strobes of the access in flight.
// Captures the read word with unselected lanes forced to zero.
// Assumes load and capture come from the sequencer and never coincide.
module sram_lane_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_lanes,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANE_W = DATA_W / LANES;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lanes_q;

    // Latch the request fields when the sequencer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (load) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            lanes_q <= host_lanes;
        end
    end

    // One capture register slice per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= lanes_q[g] ? mem_dq_in[g*LANE_W +: LANE_W]
                                                        : '0;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer. Drives the registered memory control pins and paces
// each phase with the cycle timer. Assumes the timer's expired flag reflects
// the count loaded on the accepting edge.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned WR_LOW = 1,
    parameter int unsigned RD_LOW = 1,
    parameter int          LANES  = 2,
    parameter int          CNT_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [LANES-1:0] lane_sel,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] mem_be_n,
    output logic             mem_dq_oe,
    output logic             done
);

    seq_state_t state_q;
    logic       accept;
    logic       no_lane;

    assign no_lane  = (lane_sel == '0);
    assign accept   = (state_q == ST_IDLE) && req && !no_lane;
    assign tmr_load = accept;
    assign tmr_val  = wr ? CNT_W'(WR_LOW - 1) : CNT_W'(RD_LOW - 1);
    assign capture  = (state_q == ST_READ) && tmr_expired;

    // State and registered pin drive for each phase of an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req && no_lane) begin
                        done <= 1'b1;
                    end else if (accept && wr) begin
                        state_q   <= ST_WRITE;
                        mem_ce_n  <= 1'b0;
                        mem_we_n  <= 1'b0;
                        mem_be_n  <= ~lane_sel;
                        mem_dq_oe <= 1'b1;
                    end else if (accept) begin
                        state_q  <= ST_READ;
                        mem_ce_n <= 1'b0;
                        mem_oe_n <= 1'b0;
                        mem_be_n <= ~lane_sel;
                    end
                end
                ST_WRITE: begin
                    if (tmr_expired) begin
                        state_q   <= ST_RECOVER;
                        mem_ce_n  <= 1'b1;
                        mem_we_n  <= 1'b1;
                        mem_be_n  <= '1;
                        mem_dq_oe <= 1'b0;
                    end
                end
                ST_RECOVER: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                ST_READ: begin
                    if (tmr_expired) begin
                        state_q  <= ST_IDLE;
                        mem_ce_n <= 1'b1;
                        mem_oe_n <= 1'b1;
                        mem_be_n <= '1;
                        done     <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Length of the current write-enable low run, for the pulse check.
    int unsigned we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_run <= 0;
        else if (!mem_we_n) we_low_run <= we_low_run + 1;
        else                we_low_run <= 0;
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_we_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run == WR_LOW));

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sram_byte_ctrl.sv
// Top of the byte-lane asynchronous static memory controller. Turns
// single-cycle host requests into cycle-counted memory read and write
// sequences. Assumes the pad ring combines mem_dq_out and mem_dq_oe into a
// tristate bus and returns the pin value on mem_dq_in.
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W          = 18,
    parameter int          DATA_W          = 16,
    parameter int unsigned CLK_PERIOD_PS   = 20000,
    parameter int unsigned T_WR_PULSE_PS   = 12000,
    parameter int unsigned T_WR_SETUP_PS   = 8000,
    parameter int unsigned T_WR_CYCLE_PS   = 15000,
    parameter int unsigned T_RD_ACCESS_PS  = 15000,
    parameter int unsigned T_OE_TO_DATA_PS = 7000,
    parameter int unsigned T_BE_TO_DATA_PS = 7000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] lane_sel,
    output logic [DATA_W-1:0]   rdata,
    output logic                done,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);

    localparam int          LANES      = DATA_W / 8;
    localparam int unsigned WR_CYC_ALL = ps_to_cycles(T_WR_CYCLE_PS, CLK_PERIOD_PS);
    localparam int unsigned WR_LOW     = max_u(max_u(ps_to_cycles(T_WR_PULSE_PS, CLK_PERIOD_PS),
                                                     ps_to_cycles(T_WR_SETUP_PS, CLK_PERIOD_PS)),
                                               (WR_CYC_ALL > 1) ? WR_CYC_ALL - 1 : 1);
    localparam int unsigned RD_LOW     = max_u(ps_to_cycles(T_RD_ACCESS_PS, CLK_PERIOD_PS),
                                               max_u(ps_to_cycles(T_OE_TO_DATA_PS, CLK_PERIOD_PS),
                                                     ps_to_cycles(T_BE_TO_DATA_PS, CLK_PERIOD_PS)));
    localparam int          CNT_W      = $clog2(max_u(WR_LOW, RD_LOW) + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture;

    sram_seq_fsm #(
        .WR_LOW (WR_LOW),
        .RD_LOW (RD_LOW),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .wr          (wr),
        .lane_sel    (lane_sel),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .capture     (capture),
        .mem_ce_n    (mem_ce_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_be_n    (mem_be_n),
        .mem_dq_oe   (mem_dq_oe),
        .done        (done)
    );

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .capture    (capture),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_lanes (lane_sel),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rdata      (rdata)
    );

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_lanes_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_be_n));

endmodule

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;

    localparam int CLK_PS = 5000;

    function automatic int ceil_cyc(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SETUP_EXP = ceil_cyc(8000);
    localparam int WR_EXP    = imax(imax(ceil_cyc(12000), SETUP_EXP),
                                    imax(ceil_cyc(15000) - 1, 1));
    localparam int RD_EXP    = imax(ceil_cyc(15000), ceil_cyc(7000));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  lane_sel = '0;
    logic [15:0] rdata;
    logic        done;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sram_byte_ctrl #(.CLK_PERIOD_PS(CLK_PS)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .lane_sel(lane_sel), .rdata(rdata), .done(done),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model (the device) ----------------
    logic [15:0] dev_mem [int];
    bit          touched = 1'b0;
    bit          wr_prev = 1'b0;
    int          wcnt, wstable, rcnt;
    logic [17:0] waddr, raddr;
    logic [1:0]  wlanes;
    logic [15:0] wdat;
    bit          prev_drive = 1'b0;
    bit          prev_oe_n  = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] w;
            bit wr_act;
            if (!mem_ce_n) touched = 1'b1;
            if (!mem_oe_n && mem_dq_oe) check(0, "R8 drive with oe low", 1, 0);
            if (!mem_we_n && !mem_oe_n) check(0, "R5 oe low in write", 0, 1);
            if (!mem_oe_n && prev_oe_n) check(!prev_drive, "R8 turnaround gap", prev_drive, 0);
            wr_act = !mem_ce_n && !mem_we_n;
            if (wr_act) begin
                if (!wr_prev) begin
                    wcnt = 1; wstable = 1; waddr = mem_addr;
                    wlanes = ~mem_be_n; wdat = mem_dq_out;
                end else begin
                    wcnt++;
                    if (mem_dq_out == wdat) wstable++; else wstable = 1;
                    wdat = mem_dq_out;
                    if (mem_addr != waddr || ~mem_be_n != wlanes)
                        check(0, "R2 addr/lanes moved in write", int'(mem_addr), int'(waddr));
                end
                if (!mem_dq_oe) check(0, "R3 data not driven in write", 0, 1);
            end else if (wr_prev) begin
                check(wcnt == WR_EXP, "R3 write pulse cycles", wcnt, WR_EXP);
                check(wstable >= SETUP_EXP, "R3 data setup cycles", wstable, SETUP_EXP);
                w = dev_mem.exists(int'(waddr)) ? dev_mem[int'(waddr)] : 16'h0000;
                if (wlanes[0]) w[7:0]  = wdat[7:0];
                if (wlanes[1]) w[15:8] = wdat[15:8];
                dev_mem[int'(waddr)] = w;
            end
            wr_prev = wr_act;
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                if (rcnt != 0 && mem_addr != raddr) rcnt = 0;
                raddr = mem_addr;
                rcnt++;
            end else begin
                rcnt = 0;
            end
            if (rcnt >= RD_EXP) begin
                w = dev_mem.exists(int'(raddr)) ? dev_mem[int'(raddr)] : 16'h0000;
                if (mem_be_n[0]) w[7:0]  = 8'hA5;
                if (mem_be_n[1]) w[15:8] = 8'hA5;
                mem_dq_in = w;
            end else begin
                mem_dq_in = 16'hBAD1;
            end
            prev_drive = mem_dq_oe;
            prev_oe_n  = mem_oe_n;
        end
    end

    // ---------------- scoreboard and host ----------------
    logic [15:0] exp_mem [int];

    function automatic logic [15:0] pat(input logic [17:0] a, input int k);
        return 16'((int'(a) * 40503 + k * 4369 + 17) ^ (int'(a) >> 7));
    endfunction

    function automatic logic [15:0] lane_mask(input logic [15:0] v, input logic [1:0] l);
        return {l[1] ? v[15:8] : 8'h00, l[0] ? v[7:0] : 8'h00};
    endfunction

    task automatic check_idle(input string tag);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
              tag, {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
    endtask

    task automatic host_op(input bit is_wr, input logic [17:0] a, input logic [15:0] d,
                           input logic [1:0] l, output logic [15:0] rd, output int lat);
        req = 1'b1; wr = is_wr; addr = a; wdata = d; lane_sel = l; lat = 0;
        do begin
            @(negedge clk);
            req = 1'b0;
            lat++;
        end while (!done && lat < 64);
        if (!done) check(0, "R10 done never seen", lat, 0);
        rd = rdata;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] l);
        logic [15:0] rd;
        int lat;
        logic [15:0] e;
        host_op(1'b1, a, d, l, rd, lat);
        e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
        if (l[0]) e[7:0]  = d[7:0];
        if (l[1]) e[15:8] = d[15:8];
        exp_mem[int'(a)] = e;
        if (l != 2'b00) check(lat == WR_EXP + 2, "R10 write done latency", lat, WR_EXP + 2);
        check_idle("R1 idle after write");
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] l, input string tag);
        logic [15:0] rd;
        int lat;
        logic [15:0] e;
        host_op(1'b0, a, 16'h0000, l, rd, lat);
        e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
        e = lane_mask(e, l);
        check(rd == e, tag, rd, e);
        check(lat == RD_EXP + 1, "R6 read done latency", lat, RD_EXP + 1);
        check_idle("R1 idle after read");
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int lat;
        logic [17:0] a;
        repeat (4) @(negedge clk);
        check_idle("R1 reset state");
        check(done == 1'b0, "R1 done low in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");

        // R2: walking-one addresses, plus 0 and all-ones, full words
        for (int i = 0; i < 20; i++) begin
            a = (i < 18) ? 18'(1 << i) : ((i == 18) ? 18'h00000 : 18'h3FFFF);
            do_write(a, pat(a, 0), 2'b11);
        end
        for (int i = 0; i < 20; i++) begin
            a = (i < 18) ? 18'(1 << i) : ((i == 18) ? 18'h00000 : 18'h3FFFF);
            do_read(a, 2'b11, "R2 full word readback");
        end

        // R4 / R7: every write lane set against every read lane set
        for (int i = 0; i < 6; i++) begin
            a = 18'(i * 43691 + 5);
            for (int wl = 1; wl < 4; wl++) begin
                do_write(a, 16'hFFFF ^ pat(a, 0), 2'b11);
                do_write(a, pat(a, wl), 2'(wl));
                for (int rl = 1; rl < 4; rl++)
                    do_read(a, 2'(rl), (rl == 3) ? "R4 lane write merge" : "R7 read lane mask");
            end
        end

        // R9: no lanes selected
        @(negedge clk);
        touched = 1'b0;
        host_op(1'b1, 18'h00001, 16'h1234, 2'b00, rd, lat);
        check(lat == 1, "R9 empty request done latency", lat, 1);
        repeat (3) @(negedge clk);
        check(!touched, "R9 no memory cycle", touched, 0);
        host_op(1'b0, 18'h00001, 16'h0000, 2'b00, rd, lat);
        check(lat == 1, "R9 empty read done latency", lat, 1);
        do_read(18'h00001, 2'b11, "R9 word unchanged");

        // R10: done pulse width
        req = 1'b1; wr = 1'b0; addr = 18'h00002; lane_sel = 2'b11;
        lat = 0;
        do begin @(negedge clk); req = 1'b0; lat++; end while (!done && lat < 64);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);

        // R11: request while busy is ignored
        req = 1'b1; wr = 1'b0; addr = 18'h00004; lane_sel = 2'b11;
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 18'h00008; wdata = 16'h0F0F; lane_sel = 2'b11;
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!done && lat < 64) begin @(negedge clk); lat++; end
        check(rdata == exp_mem[4], "R11 read in flight", rdata, exp_mem[4]);
        @(negedge clk);
        do_read(18'h00008, 2'b11, "R11 busy write ignored");

        // R8: write immediately followed by read
        do_write(18'h2AAAA, 16'h5AA5, 2'b11);
        do_read(18'h2AAAA, 2'b11, "R8 read after write");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule